// File: doc/BRIEF.md
# Pseudowire Receive State Controller

This block supervises the receive side of a constant-bit-rate pseudowire. It inspects the control-word sequence number and the client-fault flag of every arriving packet. It decides which packets go into the external de-jitter buffer, and for each play-out slot it chooses what is sent towards the client: buffered payload, replacement filler, or the native fault signal. The buffer memory and clock recovery sit outside the block. The block sees only the buffer's fill level and reports a read strobe for each payload it consumes.

After the connection comes up, the controller holds the client in fault until enough payload has been buffered, and only then starts play-out. Gaps in the sequence numbers are logged as lost packets. Each lost packet is later played as one slot of the filler byte, in its correct place in the stream. Two defects are declared. The first is a loss-of-signal defect, raised when no packet has been stored for a configured number of millisecond ticks. The second is a degradation defect, raised when the per-second loss ratio stays above a percentage threshold for a configured run of seconds. Either defect requests native fault injection and asks the local transmitter to set its remote-defect bit. Leaving the loss state needs the same pre-fill as the first start-up.

Top module: `pw_rx_ctrl`

## Requirements
- R1: After reset or link-up the controller is in start-up. `fault_req` is 1, and every play slot returns `play_sel`=0 (fault) with `buf_rd`=0. Normal play-out begins in the cycle after `fill_level` first reaches `PREFILL`.
- R2: Sequence numbers are 16-bit and wrap. While synchronised, a packet whose value minus the next expected value has bit 15 set is late. A late packet is discarded: `pkt_store`=0, and it changes neither the expected value nor the loss counts. A packet with `link_up`=0, or one that arrives while the tag store is full, is also not stored.
- R3: If a stored packet skips g sequence numbers, g play slots of filler (`play_sel`=2, `buf_rd`=0) come before that packet's own slot. The filler byte on `fill_byte` is 8'hAA.
- R4: In normal play-out, the slot of a packet stored with its client-fault flag set returns `play_sel`=0 with `buf_rd`=1. Its payload is consumed and not played. A clean packet returns `play_sel`=1 with `buf_rd`=1.
- R5: In normal play-out, once `LOSS_MS` millisecond ticks have passed with no packet stored, the controller enters the loss state and raises `los_defect`.
- R6: The loss state is left in the cycle after `fill_level` reaches `PREFILL`. The first packet stored after loss resynchronises the expected sequence number, and no filler is scheduled for it.
- R7: For each second, closed by `tick_s`, the interval counts as bad when lost×100 > `DEG_PCT`×expected. Expected counts stored packets plus lost ones. `deg_defect` is raised at the end of the `DEG_SECS`-th consecutive bad second. It is cleared at the end of the first second that is not bad, and a ratio of exactly `DEG_PCT` is not bad.
- R8: While either defect is active, `fault_req` and `rbit_req` are both 1.
- R9: A play slot in normal play-out that finds no stored packet returns filler (`play_sel`=2) with `buf_rd`=0.
- R10: With `link_up`=0 the controller returns to start-up in the next cycle. It clears both defects, drops all stored packet tags and forgets its sequence synchronisation.
- R11: Each `play_req` produces `play_vld` one cycle later, and `play_sel` and `buf_rd` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Pseudowire operationally up |
| pkt_valid | input | 1 | Packet header present this cycle |
| pkt_seq | input | 16 | Control-word sequence number |
| pkt_lbit | input | 1 | Client-fault flag of the packet |
| fill_level | input | FILL_W | Payloads held in the de-jitter buffer |
| play_req | input | 1 | Request for the next play-out slot |
| tick_ms | input | 1 | One-millisecond strobe |
| tick_s | input | 1 | One-second strobe |
| pkt_store | output | 1 | Write this packet's payload to the buffer |
| play_vld | output | 1 | Slot decision valid |
| play_sel | output | 2 | 0 fault, 1 buffered data, 2 filler |
| buf_rd | output | 1 | Consume one payload from the buffer |
| fill_byte | output | 8 | Replacement byte pattern |
| fault_req | output | 1 | Request native fault injection |
| los_defect | output | 1 | Loss-of-signal defect |
| deg_defect | output | 1 | Degradation defect |
| rbit_req | output | 1 | Ask transmitter to set the remote-defect bit |

## Verification
The bound checker watches relations that must hold on every cycle. Either defect forces both fault injection and the remote-defect request. A buffer read happens only in a valid slot, data slots always read and filler slots never do. A dropped link clears the defects, and loss is only entered on a millisecond tick with nothing stored. The ordering of filler slots against buffered packets, late discards at the wrap point, the exact-threshold second of the loss ratio, the run of bad seconds and the pre-fill gating on start-up and on recovery can only be shown by the bench's scenarios against its reference model.

// File: rtl/pwrx_pkg.sv
package pwrx_pkg;
    localparam int SEQ_W = 16;
    localparam int GAP_W = 8;
    localparam int CNT_W = 24;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    typedef enum logic [1:0] {
        RX_START = 2'd0,
        RX_RUN   = 2'd1,
        RX_LOSS  = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        SEL_FAULT = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_FILL  = 2'd2
    } play_sel_t;

    // one entry per stored packet: missing slots ahead of it and its fault flag
    typedef struct packed {
        logic             fault;
        logic [GAP_W-1:0] gap;
    } slot_tag_t;

    function automatic logic [GAP_W-1:0] clip_gap(input logic [SEQ_W-1:0] d);
        return (d > SEQ_W'(GAP_MAX)) ? GAP_MAX : d[GAP_W-1:0];
    endfunction

    // lost/total > pct/100 without a divider
    function automatic logic ratio_exceeds(input logic [CNT_W-1:0] lost,
                                           input logic [CNT_W-1:0] total,
                                           input logic [7:0]       pct);
        logic [CNT_W+7:0] lhs;
        logic [CNT_W+7:0] rhs;
        lhs = (CNT_W+8)'(lost)  * (CNT_W+8)'(100);
        rhs = (CNT_W+8)'(total) * (CNT_W+8)'(pct);
        return lhs > rhs;
    endfunction
endpackage

// File: rtl/pwrx_seq_track.sv
module pwrx_seq_track
    import pwrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             link_up,
    input  logic             resync,
    input  logic             pkt_valid,
    input  logic [SEQ_W-1:0] pkt_seq,
    input  logic             room,
    output logic             accept,
    output logic [GAP_W-1:0] gap
);
    logic [SEQ_W-1:0] exp_q;
    logic             synced_q;
    logic [SEQ_W-1:0] diff;
    logic             late;

    assign diff   = pkt_seq - exp_q;
    assign late   = synced_q && diff[SEQ_W-1];
    assign accept = link_up && pkt_valid && !late && room;
    assign gap    = synced_q ? clip_gap(diff) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q    <= '0;
            synced_q <= 1'b0;
        end else if (!link_up || resync) begin
            synced_q <= 1'b0;
        end else if (accept) begin
            exp_q    <= pkt_seq + SEQ_W'(1);
            synced_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pwrx_tag_fifo.sv
module pwrx_tag_fifo
    import pwrx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      push,
    input  slot_tag_t push_tag,
    input  logic      pop,
    input  logic      dec_head,
    output slot_tag_t head_tag,
    output logic      empty,
    output logic      full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    slot_tag_t     mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign head_tag = mem[rd_q];
    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= nxt(wr_q);
            if (pop)  rd_q <= nxt(rd_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_tag;
        if (dec_head) mem[rd_q].gap <= mem[rd_q].gap - GAP_W'(1);
    end
endmodule

// File: rtl/pwrx_ratio_mon.sv
module pwrx_ratio_mon
    import pwrx_pkg::*;
#(
    parameter int DEG_PCT  = 15,
    parameter int DEG_SECS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             accept,
    input  logic [GAP_W-1:0] gap,
    input  logic             tick_s,
    output logic             deg
);
    localparam int RW = $clog2(DEG_SECS + 1);

    logic [CNT_W-1:0] tot_q, lost_q, add_tot, add_lost;
    logic [RW-1:0]    run_q, run_inc;
    logic             bad;

    assign add_tot  = accept ? CNT_W'(gap) + CNT_W'(1) : '0;
    assign add_lost = accept ? CNT_W'(gap) : '0;
    assign bad      = ratio_exceeds(lost_q, tot_q, 8'(DEG_PCT));
    assign run_inc  = (run_q == RW'(DEG_SECS)) ? run_q : run_q + RW'(1);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            tot_q  <= '0;
            lost_q <= '0;
            run_q  <= '0;
            deg    <= 1'b0;
        end else if (tick_s) begin
            tot_q  <= add_tot;
            lost_q <= add_lost;
            if (bad) begin
                run_q <= run_inc;
                deg   <= (run_inc >= RW'(DEG_SECS));
            end else begin
                run_q <= '0;
                deg   <= 1'b0;
            end
        end else begin
            tot_q  <= tot_q + add_tot;
            lost_q <= lost_q + add_lost;
        end
    end
endmodule

// File: rtl/pw_rx_ctrl.sv
module pw_rx_ctrl
    import pwrx_pkg::*;
#(
    parameter int         FILL_W       = 12,
    parameter int         PREFILL      = 4,
    parameter int         LOSS_MS      = 1,
    parameter int         DEG_PCT      = 15,
    parameter int         DEG_SECS     = 7,
    parameter int         TAG_DEPTH    = 8,
    parameter logic [7:0] FILL_PATTERN = 8'hAA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up,
    input  logic              pkt_valid,
    input  logic [15:0]       pkt_seq,
    input  logic              pkt_lbit,
    input  logic [FILL_W-1:0] fill_level,
    input  logic              play_req,
    input  logic              tick_ms,
    input  logic              tick_s,
    output logic              pkt_store,
    output logic              play_vld,
    output logic [1:0]        play_sel,
    output logic              buf_rd,
    output logic [7:0]        fill_byte,
    output logic              fault_req,
    output logic              los_defect,
    output logic              deg_defect,
    output logic              rbit_req
);
    localparam int MS_W = $clog2(LOSS_MS + 1);

    rx_state_t        state_q;
    logic [MS_W-1:0]  ms_q;
    logic             running, prefilled, slot, loss_fire;
    logic             accept, empty, full, fifo_pop, fifo_dec;
    logic [GAP_W-1:0] gap;
    slot_tag_t        head, new_tag;
    play_sel_t        sel_d;

    assign running   = (state_q == RX_RUN);
    assign prefilled = (fill_level >= FILL_W'(PREFILL));
    assign slot      = play_req && running;
    assign fifo_pop  = slot && !empty && (head.gap == '0);
    assign fifo_dec  = slot && !empty && (head.gap != '0);
    assign loss_fire = running && !accept && tick_ms && (ms_q == MS_W'(LOSS_MS - 1));
    assign new_tag   = '{fault: pkt_lbit, gap: gap};

    pwrx_seq_track u_seq (
        .clk(clk), .rst(rst), .link_up(link_up), .resync(loss_fire),
        .pkt_valid(pkt_valid), .pkt_seq(pkt_seq), .room(!full),
        .accept(accept), .gap(gap)
    );

    pwrx_tag_fifo #(.DEPTH(TAG_DEPTH)) u_tags (
        .clk(clk), .rst(rst), .flush(!link_up), .push(accept),
        .push_tag(new_tag), .pop(fifo_pop), .dec_head(fifo_dec),
        .head_tag(head), .empty(empty), .full(full)
    );

    pwrx_ratio_mon #(.DEG_PCT(DEG_PCT), .DEG_SECS(DEG_SECS)) u_ratio (
        .clk(clk), .rst(rst), .enable(link_up), .accept(accept),
        .gap(gap), .tick_s(tick_s), .deg(deg_defect)
    );

    always_comb begin
        if (!running)             sel_d = SEL_FAULT;
        else if (empty)           sel_d = SEL_FILL;
        else if (head.gap != '0)  sel_d = SEL_FILL;
        else if (head.fault)      sel_d = SEL_FAULT;
        else                      sel_d = SEL_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RX_START;
            ms_q     <= '0;
            play_vld <= 1'b0;
            play_sel <= SEL_FAULT;
            buf_rd   <= 1'b0;
        end else begin
            play_vld <= play_req;
            play_sel <= sel_d;
            buf_rd   <= fifo_pop;
            if (!link_up) begin
                state_q <= RX_START;
                ms_q    <= '0;
            end else begin
                unique case (state_q)
                    RX_START, RX_LOSS: begin
                        if (prefilled) begin
                            state_q <= RX_RUN;
                            ms_q    <= '0;
                        end
                    end
                    RX_RUN: begin
                        if (accept) begin
                            ms_q <= '0;
                        end else if (loss_fire) begin
                            state_q <= RX_LOSS;
                            ms_q    <= '0;
                        end else if (tick_ms) begin
                            ms_q <= ms_q + MS_W'(1);
                        end
                    end
                    default: state_q <= RX_START;
                endcase
            end
        end
    end

    assign pkt_store  = accept;
    assign fill_byte  = FILL_PATTERN;
    assign los_defect = (state_q == RX_LOSS);
    assign fault_req  = !running || deg_defect;
    assign rbit_req   = los_defect || deg_defect;
endmodule

// File: rtl/pwrx_rx_chk.sv
module pwrx_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       link_up,
    input logic       pkt_valid,
    input logic       tick_ms,
    input logic       pkt_store,
    input logic       play_vld,
    input logic [1:0] play_sel,
    input logic       buf_rd,
    input logic       fault_req,
    input logic       los_defect,
    input logic       deg_defect,
    input logic       rbit_req
);
    // R8
    defect_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (los_defect || deg_defect) |-> (fault_req && rbit_req));

    // R11
    rd_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        buf_rd |-> play_vld);

    // R3
    fill_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (play_vld && play_sel == 2'd2) |-> !buf_rd);

    // R4
    data_read_chk: assert property (@(posedge clk) disable iff (rst)
        (play_vld && play_sel == 2'd1) |-> buf_rd);

    // R10
    link_down_chk: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> (!los_defect && !deg_defect && fault_req));

    // R5
    loss_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(los_defect) |-> $past(tick_ms && !pkt_store));

    // R2
    store_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_store |-> (pkt_valid && link_up));
endmodule

bind pw_rx_ctrl pwrx_rx_chk u_rx_chk (.*);

// File: tb/pw_rx_ctrl_test.sv
module pw_rx_ctrl_test;
    localparam int PREF  = 4;
    localparam int LMS   = 3;
    localparam int PCT   = 15;
    localparam int SECS  = 7;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_up = 1'b0, pkt_valid = 1'b0, pkt_lbit = 1'b0;
    logic [15:0] pkt_seq = '0;
    logic [11:0] fill_level = '0;
    logic play_req = 1'b0, tick_ms = 1'b0, tick_s = 1'b0;
    logic pkt_store, play_vld, buf_rd, fault_req, los_defect, deg_defect, rbit_req;
    logic [1:0] play_sel;
    logic [7:0] fill_byte;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pw_rx_ctrl #(.LOSS_MS(LMS)) uut (
        .clk(clk), .rst(rst), .link_up(link_up), .pkt_valid(pkt_valid),
        .pkt_seq(pkt_seq), .pkt_lbit(pkt_lbit), .fill_level(fill_level),
        .play_req(play_req), .tick_ms(tick_ms), .tick_s(tick_s),
        .pkt_store(pkt_store), .play_vld(play_vld), .play_sel(play_sel),
        .buf_rd(buf_rd), .fill_byte(fill_byte), .fault_req(fault_req),
        .los_defect(los_defect), .deg_defect(deg_defect), .rbit_req(rbit_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int  m_st = 0;
    bit  m_sync = 0;
    int  m_exp = 0;
    int  m_gq[$];
    bit  m_lq[$];
    int  m_ms = 0, m_tot = 0, m_lost = 0, m_run = 0;
    bit  m_deg = 0, m_pv = 0, m_rd = 0;
    int  m_ps = 0;

    function automatic bit m_accept();
        int d;
        d = (int'(pkt_seq) - m_exp) & 16'hFFFF;
        return link_up && pkt_valid && !(m_sync && d >= 32768) && (m_gq.size() < DEPTH);
    endfunction

    function automatic int m_gap();
        int d;
        d = (int'(pkt_seq) - m_exp) & 16'hFFFF;
        if (!m_sync) return 0;
        return (d > 255) ? 255 : d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_sync = 0; m_exp = 0; m_gq.delete(); m_lq.delete();
            m_ms = 0; m_tot = 0; m_lost = 0; m_run = 0; m_deg = 0;
            m_pv = 0; m_rd = 0; m_ps = 0;
        end else begin
            bit acc; int g; bit bad;
            acc = m_accept();
            g   = m_gap();
            m_pv = play_req; m_rd = 0;
            if (play_req) begin
                if (m_st != 1) m_ps = 0;
                else if (m_gq.size() == 0) m_ps = 2;
                else if (m_gq[0] > 0) begin m_ps = 2; m_gq[0] = m_gq[0] - 1; end
                else begin
                    m_ps = m_lq[0] ? 0 : 1; m_rd = 1;
                    void'(m_gq.pop_front()); void'(m_lq.pop_front());
                end
            end
            if (acc) begin
                m_gq.push_back(g); m_lq.push_back(pkt_lbit);
                m_exp = (int'(pkt_seq) + 1) & 16'hFFFF; m_sync = 1;
            end
            if (!link_up) begin
                m_tot = 0; m_lost = 0; m_run = 0; m_deg = 0;
            end else if (tick_s) begin
                bad = (m_lost * 100) > (PCT * m_tot);
                if (bad) begin
                    if (m_run < SECS) m_run++;
                    m_deg = (m_run >= SECS);
                end else begin
                    m_run = 0; m_deg = 0;
                end
                m_tot = acc ? 1 + g : 0; m_lost = acc ? g : 0;
            end else if (acc) begin
                m_tot += 1 + g; m_lost += g;
            end
            if (!link_up) begin
                m_st = 0; m_ms = 0; m_sync = 0; m_gq.delete(); m_lq.delete();
            end else begin
                case (m_st)
                    0, 2: if (fill_level >= PREF) begin m_st = 1; m_ms = 0; end
                    default: begin
                        if (acc) m_ms = 0;
                        else if (tick_ms) begin
                            if (m_ms == LMS - 1) begin m_st = 2; m_ms = 0; m_sync = 0; end
                            else m_ms++;
                        end
                    end
                endcase
            end
        end
    end

    // cycle-by-cycle comparison, mid-cycle
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit e_los;
            e_los = (m_st == 2);
            chk(pkt_store == m_accept(), "R2 pkt_store", pkt_store, m_accept());
            chk(fault_req == ((m_st != 1) || m_deg), "R1 fault_req", fault_req, (m_st != 1) || m_deg);
            chk(los_defect == e_los, "R5 los_defect", los_defect, e_los);
            chk(deg_defect == m_deg, "R7 deg_defect", deg_defect, m_deg);
            chk(rbit_req == (e_los || m_deg), "R8 rbit_req", rbit_req, e_los || m_deg);
            chk(play_vld == m_pv, "R11 play_vld", play_vld, m_pv);
            chk(buf_rd == m_rd, "R4 buf_rd", buf_rd, m_rd);
            if (m_pv) chk(play_sel == 2'(m_ps), "R3 play_sel", play_sel, m_ps);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    bit last_store;
    task automatic send(input int s, input bit l);
        pkt_valid = 1; pkt_seq = 16'(s); pkt_lbit = l;
        @(negedge clk); last_store = pkt_store;
        step();
        pkt_valid = 0; pkt_lbit = 0;
    endtask

    int got_sel; bit got_rd;
    task automatic play();
        play_req = 1; step(); play_req = 0;
        @(negedge clk); got_sel = play_sel; got_rd = buf_rd;
        step();
    endtask

    task automatic pulse_ms();
        tick_ms = 1; step(); tick_ms = 0;
        @(negedge clk); step();
    endtask

    task automatic pulse_s();
        tick_s = 1; step(); tick_s = 0;
        @(negedge clk); step();
    endtask

    int nx;

    initial begin : main
        repeat (3) step();
        rst = 0; step();
        @(negedge clk);
        chk(fault_req == 1, "R1 reset fault_req", fault_req, 1);
        chk(los_defect == 0 && deg_defect == 0, "R1 reset defects", los_defect, 0);
        chk(fill_byte == 8'hAA, "R3 fill_byte", fill_byte, 8'hAA);
        step();

        link_up = 1; step();
        play();
        chk(got_sel == 0 && got_rd == 0, "R1 start-up slot", got_sel, 0);
        for (int i = 0; i < 4; i++) send(100 + i, 0);
        fill_level = 3; step(); @(negedge clk);
        chk(fault_req == 1, "R1 below prefill", fault_req, 1);
        step();
        fill_level = 4; step(); @(negedge clk);
        chk(fault_req == 0, "R1 prefill reached", fault_req, 0);
        step();
        for (int i = 0; i < 4; i++) begin
            play();
            chk(got_sel == 1 && got_rd == 1, "R4 clean data slot", got_sel, 1);
        end

        send(104, 0);
        send(107, 0);
        send(105, 0);
        chk(last_store == 0, "R2 late packet dropped", last_store, 0);
        play(); chk(got_sel == 1, "R3 before gap", got_sel, 1);
        play(); chk(got_sel == 2 && got_rd == 0, "R3 first filler", got_sel, 2);
        play(); chk(got_sel == 2 && got_rd == 0, "R3 second filler", got_sel, 2);
        play(); chk(got_sel == 1 && got_rd == 1, "R3 after gap", got_sel, 1);
        play(); chk(got_sel == 2 && got_rd == 0, "R9 underrun filler", got_sel, 2);

        send(108, 1);
        play(); chk(got_sel == 0 && got_rd == 1, "R4 fault-flag slot", got_sel, 0);

        fill_level = 0;
        pulse_ms(); pulse_ms();
        @(negedge clk); chk(los_defect == 0, "R5 before window", los_defect, 0); step();
        pulse_ms();
        @(negedge clk);
        chk(los_defect == 1, "R5 loss declared", los_defect, 1);
        chk(fault_req == 1 && rbit_req == 1, "R8 loss outputs", rbit_req, 1);
        step();

        send(500, 0);
        fill_level = 4; step(); @(negedge clk);
        chk(los_defect == 0 && fault_req == 0, "R6 recovered", los_defect, 0);
        step();
        play(); chk(got_sel == 1 && got_rd == 1, "R6 resync no filler", got_sel, 1);
        nx = 501;

        pulse_s();
        for (int k = 0; k < 2; k++) begin send(nx, 0); nx++; end
        play(); play();
        pulse_s();
        for (int s = 1; s <= SECS; s++) begin
            for (int k = 0; k < 2; k++) begin send(nx + 1, 0); nx += 2; end
            repeat (4) play();
            pulse_s();
            @(negedge clk);
            if (s < SECS) chk(deg_defect == 0, "R7 run not complete", deg_defect, 0);
            else begin
                chk(deg_defect == 1, "R7 degradation raised", deg_defect, 1);
                chk(fault_req == 1 && rbit_req == 1, "R8 degradation outputs", fault_req, 1);
            end
            step();
        end
        for (int i = 0; i < 17; i++) begin
            if (i == 0 || i == 5 || i == 10) begin send(nx + 1, 0); nx += 2; play(); play(); end
            else begin send(nx, 0); nx++; play(); end
        end
        pulse_s();
        @(negedge clk);
        chk(deg_defect == 0, "R7 exact threshold clears", deg_defect, 0);
        step();

        fill_level = 0;
        for (int k = 0; k < 3; k++) begin send(nx, 1); nx++; end
        link_up = 0; step(); @(negedge clk);
        chk(fault_req == 1 && los_defect == 0 && deg_defect == 0, "R10 link down", fault_req, 1);
        step();
        link_up = 1; step();
        play(); chk(got_sel == 0 && got_rd == 0, "R10 back in start-up", got_sel, 0);
        send(16'hFFFF, 0);
        send(16'h0000, 0);
        chk(last_store == 1, "R2 wrap accepted", last_store, 1);
        send(16'hFFFF, 0);
        chk(last_store == 0, "R2 wrap late dropped", last_store, 0);
        fill_level = 4; step(); step();
        play(); chk(got_sel == 1 && got_rd == 1, "R10 stale tags dropped", got_sel, 1);
        play(); chk(got_sel == 1 && got_rd == 1, "R2 wrap no filler", got_sel, 1);

        repeat (2) step();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule